// File: doc/BRIEF.md
# Raster Horizontal/Vertical Position Counter

This block keeps the horizontal and vertical raster positions of a video processor. Each pixel-step pulse moves the horizontal count one place along a mode-dependent path. In blanking, that path jumps backwards instead of simply wrapping. The vertical count does not advance at the end of the line. It moves on the step in which the horizontal count enters a fixed position inside horizontal blanking. In the 28-cell height, the vertical count also jumps backwards inside vertical blanking.

Two width modes are supported, 32-cell and 40-cell, and two height modes, 28-cell and 30-cell. A requested mode is taken over only at one point of the frame, so a sequence that has started is never disturbed. A latch strobe captures the two counts into a 16-bit position word. An interlace option reformats the vertical byte of that word.

There is no streaming interface. The position word is plain registered state that a reader samples after it strobes the latch, and it needs no back-pressure. All other pins are plain control and status pins.

Top module: `raster_pos_counter`

## Requirements
- R1: After reset the horizontal and vertical counts are 0, the active modes are 32-cell width and 28-cell height, and the position word is 0.
- R2: In 32-cell width, each pixel step takes the horizontal count from 0 up to 0x94, then to 0xE9, then up to 0xFF, then to 0. A line is 172 steps.
- R3: In 40-cell width, each pixel step takes the horizontal count from 0 up to 0xB6, then to 0xE4, then up to 0xFF, then to 0. A line is 211 steps.
- R4: The vertical count changes only on the pixel step in which the horizontal count becomes 0x84 (32-cell) or 0xA5 (40-cell).
- R5: In 28-cell height, the vertical count runs 0 up to 0xEA, then jumps to 0xE5, then runs up to 0xFF, then wraps to 0.
- R6: In 30-cell height, the vertical count runs 0 up to 0xFF and then wraps to 0, with no jump.
- R7: hblank is 1 exactly when the horizontal count exceeds 0x7F (32-cell) or 0x9F (40-cell).
- R8: vblank is 1 exactly when the vertical count exceeds 0xDF (28-cell) or 0xEF (30-cell).
- R9: The width and height requests are copied into the active modes only on a pixel step where the horizontal count is 0xFF and the vertical count is 0. At all other times, changing the requests has no effect.
- R10: While pix_en is 0, both counts hold their values.
- R11: On a clock edge with latch high, the position word takes the pre-edge horizontal count in bits 7:0 and the vertical byte in bits 15:8. Without latch, the word holds its value.
- R12: With interlace high at the latch edge, the vertical byte is the vertical count rotated left by one: count bits 6:0 in word bits 15:9 and count bit 7 in word bit 8. With interlace low, the vertical byte is the plain count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel step enable |
| wide_req | input | 1 | Requested width: 1 = 40-cell, 0 = 32-cell |
| tall_req | input | 1 | Requested height: 1 = 30-cell, 0 = 28-cell |
| interlace | input | 1 | Interlace format for the latched vertical byte |
| latch | input | 1 | Capture strobe for the position word |
| hpos | output | 8 | Horizontal count |
| vpos | output | 8 | Vertical count |
| hblank | output | 1 | Horizontal count is outside the active range |
| vblank | output | 1 | Vertical count is outside the active range |
| pos_word | output | 16 | Latched position word |

## Verification
The bench runs full frames in both mode pairs and checks every step. This catches a design that wraps at the end of the active range, misses the blanking jumps, or jumps one step late. It also catches a vertical count that advances at line end instead of at the fixed horizontal position, and a 28-cell frame that skips the backward jump to 0xE5. Mode requests are changed in mid-frame and while pix_en toggles. A design that takes the request early would corrupt a line that is already in progress. Latches are taken with interlace both on and off, which exposes a wrong bit rotation or a capture of the post-edge counts.

// File: rtl/rpc_pkg.sv
package rpc_pkg;

  typedef struct packed {
    logic wide;  // 1: 40-cell width
    logic tall;  // 1: 30-cell height
  } rpc_mode_t;

  function automatic logic [7:0] rpc_il_byte(input logic [7:0] v);
    return {v[6:0], v[7]};
  endfunction

endpackage

// File: rtl/rpc_seq_ctr.sv
module rpc_seq_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic [W-1:0] jump_at,
  input  logic [W-1:0] jump_to,
  output logic [W-1:0] cnt
);

  logic [W-1:0] cnt_nx;

  always_comb begin
    if (cnt == jump_at) cnt_nx = jump_to;
    else                cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (adv) cnt <= cnt_nx;
  end

  // the count only moves on an enabled step
  p_seq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt));

endmodule

// File: rtl/rpc_mode_ctl.sv
module rpc_mode_ctl
  import rpc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pix_en,
  input  logic [W-1:0] hpos,
  input  logic [W-1:0] vpos,
  input  logic         wide_req,
  input  logic         tall_req,
  output rpc_mode_t    mode
);

  logic commit;
  assign commit = pix_en && (&hpos) && (vpos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (commit) begin
      mode.wide <= wide_req;
      mode.tall <= tall_req;
    end
  end

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(pix_en && (&hpos) && (vpos == '0)) |=> $stable(mode));

endmodule

// File: rtl/rpc_readout.sv
module rpc_readout
  import rpc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           latch,
  input  logic           interlace,
  input  logic [W-1:0]   hpos,
  input  logic [W-1:0]   vpos,
  output logic [2*W-1:0] word
);

  logic [W-1:0] vbyte;
  assign vbyte = interlace ? rpc_il_byte(vpos) : vpos;

  always_ff @(posedge clk) begin
    if (!rst_n)     word <= '0;
    else if (latch) word <= {vbyte, hpos};
  end

  p_word_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(word));

  p_word_hpart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    latch |=> word[W-1:0] == $past(hpos));

  p_word_il_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && interlace) |=> word[W] == $past(vpos[W-1]));

endmodule

// File: rtl/raster_pos_counter.sv
module raster_pos_counter
  import rpc_pkg::*;
#(
  parameter int         W           = 8,
  parameter logic [7:0] H32_LAST    = 8'h94,
  parameter logic [7:0] H32_RESUME  = 8'hE9,
  parameter logic [7:0] H40_LAST    = 8'hB6,
  parameter logic [7:0] H40_RESUME  = 8'hE4,
  parameter logic [7:0] H32_VSTEP   = 8'h84,
  parameter logic [7:0] H40_VSTEP   = 8'hA5,
  parameter logic [7:0] V28_LAST    = 8'hEA,
  parameter logic [7:0] V28_RESUME  = 8'hE5,
  parameter logic [7:0] H32_ACT_END = 8'h7F,
  parameter logic [7:0] H40_ACT_END = 8'h9F,
  parameter logic [7:0] V28_ACT_END = 8'hDF,
  parameter logic [7:0] V30_ACT_END = 8'hEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pix_en,
  input  logic            wide_req,
  input  logic            tall_req,
  input  logic            interlace,
  input  logic            latch,
  output logic [W-1:0]    hpos,
  output logic [W-1:0]    vpos,
  output logic            hblank,
  output logic            vblank,
  output logic [2*W-1:0]  pos_word
);

  localparam logic [W-1:0] CNT_TOP = '1;

  rpc_mode_t    mode;
  logic [W-1:0] h_jump_at, h_jump_to, v_jump_at, v_jump_to;
  logic [W-1:0] vstep, vstep_pre;
  logic         v_adv;

  always_comb begin
    h_jump_at = mode.wide ? W'(H40_LAST)   : W'(H32_LAST);
    h_jump_to = mode.wide ? W'(H40_RESUME) : W'(H32_RESUME);
    vstep     = mode.wide ? W'(H40_VSTEP)  : W'(H32_VSTEP);
    vstep_pre = vstep - 1'b1;
    // the 30-cell height has no jump: its jump point is the natural wrap
    v_jump_at = mode.tall ? CNT_TOP : W'(V28_LAST);
    v_jump_to = mode.tall ? '0      : W'(V28_RESUME);
  end

  assign v_adv = pix_en && (hpos == vstep_pre);

  rpc_mode_ctl #(.W(W)) u_mode (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .hpos(hpos), .vpos(vpos),
    .wide_req(wide_req), .tall_req(tall_req), .mode(mode)
  );

  rpc_seq_ctr #(.W(W)) u_hctr (
    .clk(clk), .rst_n(rst_n), .adv(pix_en),
    .jump_at(h_jump_at), .jump_to(h_jump_to), .cnt(hpos)
  );

  rpc_seq_ctr #(.W(W)) u_vctr (
    .clk(clk), .rst_n(rst_n), .adv(v_adv),
    .jump_at(v_jump_at), .jump_to(v_jump_to), .cnt(vpos)
  );

  rpc_readout #(.W(W)) u_rd (
    .clk(clk), .rst_n(rst_n), .latch(latch), .interlace(interlace),
    .hpos(hpos), .vpos(vpos), .word(pos_word)
  );

  assign hblank = hpos > (mode.wide ? W'(H40_ACT_END) : W'(H32_ACT_END));
  assign vblank = vpos > (mode.tall ? W'(V30_ACT_END) : W'(V28_ACT_END));

  p_h32_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.wide |-> !(hpos > W'(H32_LAST) && hpos < W'(H32_RESUME)));

  p_h40_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode.wide |-> !(hpos > W'(H40_LAST) && hpos < W'(H40_RESUME)));

  p_v_moves_at_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vpos) |-> hpos == vstep);

  p_v28_jump_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode.tall && vpos == W'(V28_LAST) && pix_en && hpos == vstep_pre)
      |=> vpos == W'(V28_RESUME));

  p_pix_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(hpos) && $stable(vpos)));

endmodule

// File: tb/raster_pos_counter_tb.sv
module raster_pos_counter_tb;

  typedef struct {
    logic [7:0]  h, v;
    logic        hb, vb;
    logic [15:0] w;
    logic        pen, wide, tall, il_used;
    int          since;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pix_en = 1'b0, wide_req = 1'b0, tall_req = 1'b0, interlace = 1'b0, latch = 1'b0;
  logic [7:0]  hpos, vpos;
  logic        hblank, vblank;
  logic [15:0] pos_word;

  int total = 0, bad = 0;
  bit done = 0;
  exp_t q[$];

  // reference state built from the requirements
  logic [7:0]  m_h = 0, m_v = 0;
  logic        m_wide = 0, m_tall = 0, m_il = 0;
  logic [15:0] m_w = 0;
  int          m_since = 1000;

  always #2.5 clk = ~clk;

  raster_pos_counter u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .wide_req(wide_req),
    .tall_req(tall_req), .interlace(interlace), .latch(latch),
    .hpos(hpos), .vpos(vpos), .hblank(hblank), .vblank(vblank), .pos_word(pos_word)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // driver: one clock of stimulus, expected post-edge state pushed to the scoreboard
  task automatic cyc(input bit pen, input bit lat, input bit il, input bit wr, input bit tr);
    logic [7:0] nh, nv;
    logic       nwide, ntall;
    exp_t e;
    @(negedge clk);
    pix_en = pen; latch = lat; interlace = il; wide_req = wr; tall_req = tr;
    nh = m_h; nv = m_v; nwide = m_wide; ntall = m_tall;
    if (lat) begin
      m_w = {(il ? {m_v[6:0], m_v[7]} : m_v), m_h};  // R11 R12
      m_il = il;
    end
    if (pen) begin
      if (m_wide) nh = (m_h == 8'hB6) ? 8'hE4 : m_h + 8'd1;  // R3
      else        nh = (m_h == 8'h94) ? 8'hE9 : m_h + 8'd1;  // R2
      if (nh == (m_wide ? 8'hA5 : 8'h84)) begin               // R4
        if (m_tall) nv = m_v + 8'd1;                           // R6
        else        nv = (m_v == 8'hEA) ? 8'hE5 : m_v + 8'd1; // R5
      end
      if (m_h == 8'hFF && m_v == 8'h00) begin                  // R9
        nwide = wr; ntall = tr; m_since = 0;
      end
    end
    m_since++;
    m_h = nh; m_v = nv; m_wide = nwide; m_tall = ntall;
    e.h = m_h; e.v = m_v; e.w = m_w; e.pen = pen; e.il_used = m_il;
    e.wide = m_wide; e.tall = m_tall; e.since = m_since;
    e.hb = m_h > (m_wide ? 8'h9F : 8'h7F);  // R7
    e.vb = m_v > (m_tall ? 8'hEF : 8'hDF);  // R8
    q.push_back(e);
  endtask

  // monitor: compare the design against the scoreboard after each edge
  initial begin
    exp_t e;
    string rq;
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        rq = !e.pen ? "R10" : (e.since < 400 ? "R9" : (e.wide ? "R3" : "R2"));
        chk(hpos == e.h, rq, hpos, e.h);
        rq = !e.pen ? "R10" : (e.h == (e.wide ? 8'hA5 : 8'h84) ? "R4" : (e.tall ? "R6" : "R5"));
        chk(vpos == e.v, rq, vpos, e.v);
        chk(hblank == e.hb, "R7", hblank, e.hb);
        chk(vblank == e.vb, "R8", vblank, e.vb);
        chk(pos_word == e.w, e.il_used ? "R12" : "R11", pos_word, e.w);
      end
    end
  end

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(hpos == 0, "R1", hpos, 0);
    chk(vpos == 0, "R1", vpos, 0);
    chk(pos_word == 0, "R1", pos_word, 0);
    chk(hblank == 0 && vblank == 0, "R1", {hblank, vblank}, 0);
    // irregular enable, requests raised early: must be ignored (R9, R10)
    for (int i = 0; i < 300; i++)
      cyc(i % 3 != 0, i % 50 == 7, i % 100 == 7, 1'b1, 1'b1);
    // rest of the first 32/28 frame, then 40/30 frames
    for (int i = 0; i < 100000; i++)
      cyc(1'b1, i % 61 == 0, (i / 61) % 2 == 1, 1'b1, 1'b1);
    // requests dropped mid-frame: take effect only at the next frame point
    for (int i = 0; i < 60000; i++)
      cyc(i % 97 != 5, i % 53 == 0, (i / 53) % 2 == 0, 1'b0, 1'b0);
    while (q.size() > 0) @(posedge clk);
    @(posedge clk); #2;
    finish_up();
  end

endmodule